// File: doc/BRIEF.md
# Multi-Mode Host Port with Page Window

This block is a parallel slave port. An external host uses it to read and write 32-bit words on an internal memory bus. The host picks one of three pin modes. In the 16-bit multiplexed mode, address and data share the low half of one bus, and each word moves as two half-word cycles. In the 32-bit multiplexed mode, address and data share the full-width bus. In the separate-bus mode, a 16-bit address bus and a 32-bit data bus are used. In both multiplexed modes, an address-latch strobe captures the address before the data strobes.

A window mode can be turned on to confine every host access to one 64 KB page. The 16-bit host offset is joined to a page base register, which forms the upper address bits. Only the local CPU can load that register, through a dedicated write port. No host pin and no host transaction reaches it.

Each data strobe that needs the internal bus starts one single-beat request. The request is held steady until the bus acknowledges it. While the request is open, the host sees its ready line low.

Top module: `hpw_host_port`

## Requirements
- R1: After reset, `h_ready` is 1, `m_req` is 0, `h_rdata` is 0 and the page base is 0.
- R2: With `mode_sel` = 1 (32-bit multiplexed), a pulse on `h_ale` latches all 32 bits of `h_ad_i` as the address. A later data strobe issues one access to that address. For a write, the data is `h_ad_i`.
- R3: With `mode_sel` = 2 or 3 (separate buses), a data strobe takes its address from `h_addr_i`, zero-extended to 32 bits. For a write, the data is `h_ad_i`. `h_ale` plays no part.
- R4: With `mode_sel` = 0 (16-bit multiplexed), a pulse on `h_ale` latches `h_ad_i[15:0]`, zero-extended, as the address. Bits 31:16 of `h_ad_i` are ignored. The pulse also resets the half-word sequence to "low half next".
- R5: In mode 0, the first write strobe stores `h_ad_i[15:0]` as the low half and issues no bus request. The second write strobe issues one write of {second `h_ad_i[15:0]`, stored low half}.
- R6: In mode 0, the first read strobe issues one bus read and returns the low half of the read word on `h_rdata[15:0]`, with bits 31:16 at zero. The second read strobe issues no bus request and returns the high half in the same position.
- R7: While `win_en` is 1, the internal address in every mode is {page base, 16-bit host offset}. The page base used is the value it held when the access was issued.
- R8: The page base changes only on `cpu_page_we`, which loads `cpu_page_wdata`. Host accesses of any kind leave it unchanged.
- R9: `m_req` rises in the cycle after an accepted strobe. `m_addr`, `m_we` and `m_wdata` stay stable until `m_ack` is sampled. `m_req` drops in the following cycle. `h_ready` is low exactly while `m_req` is high, so with an acknowledge L cycles late the host sees L+2 busy cycles.
- R10: For a read in modes 1 to 3, the word on `m_rdata` at the acknowledge appears on `h_rdata` from the next cycle on. A write acknowledge leaves `h_rdata` unchanged.
- R11: A data strobe while `h_ready` is 0 is ignored. It changes neither the open request nor the number of bus accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0: 16-bit multiplexed, 1: 32-bit multiplexed, 2/3: separate buses |
| win_en | input | 1 | Confine host accesses to the 64 KB page |
| cpu_page_we | input | 1 | CPU-side load of the page base |
| cpu_page_wdata | input | 16 | New page base (address bits 31:16) |
| h_ale | input | 1 | Host address-latch strobe (multiplexed modes) |
| h_strobe | input | 1 | Host data strobe, one cycle per half-word or word |
| h_rnw | input | 1 | 1 = read, 0 = write |
| h_ad_i | input | 32 | Host address/data bus in |
| h_addr_i | input | 16 | Host address bus (separate mode) |
| h_rdata | output | 32 | Read data to host |
| h_ready | output | 1 | 1 = port free, 0 = host cycle stretched |
| m_req | output | 1 | Internal bus request |
| m_we | output | 1 | Internal bus write enable |
| m_addr | output | 32 | Internal bus address |
| m_wdata | output | 32 | Internal bus write data |
| m_rdata | input | 32 | Internal bus read data |
| m_ack | input | 1 | Internal bus acknowledge |

## Verification
The assertions check the following on every cycle:
- the request holds steady until its acknowledge, and drops straight after it;
- ready returns after the acknowledge;
- a strobe on a busy port leaves the bus outputs untouched;
- the page base moves only on a CPU load;
- a windowed access carries the page base that held at issue.

Only the bench scenarios can show the following:
- the address each mode forms, including zero-extension and the ignored upper half in 16-bit mode;
- the half-word ordering and the number of bus accesses it costs;
- the data returned to the host;
- the exact busy length for a given acknowledge delay.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  typedef enum logic [1:0] {
    HPW_MUX16   = 2'd0,
    HPW_MUX32   = 2'd1,
    HPW_SEP     = 2'd2,
    HPW_SEP_ALT = 2'd3
  } hpw_mode_e;

  function automatic logic is_sep(input hpw_mode_e m);
    return (m == HPW_SEP) || (m == HPW_SEP_ALT);
  endfunction
endpackage

// File: rtl/hpw_page_reg.sv
module hpw_page_reg #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] page_o
);
  logic [PW-1:0] page_q, page_d;

  always_comb begin
    page_d = page_q;
    if (we) page_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign page_o = page_q;

  AST_PAGE_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(page_q)); // R8
endmodule

// File: rtl/hpw_addr_latch.sv
module hpw_addr_latch
  import hpw_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 16,
  localparam int PW   = DW - OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hpw_mode_e        mode,
  input  logic             ale,
  input  logic [DW-1:0]    ad_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic             win_en,
  input  logic [PW-1:0]    page,
  output logic [DW-1:0]    eff_addr
);
  logic [DW-1:0] ale_q, ale_d;
  logic [DW-1:0] src;

  always_comb begin
    ale_d = ale_q;
    if (ale && !is_sep(mode)) begin
      if (mode == HPW_MUX32) ale_d = ad_i;
      else                   ale_d = {{PW{1'b0}}, ad_i[OFS_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ale_q <= '0;
    else        ale_q <= ale_d;
  end

  always_comb begin
    if (is_sep(mode)) src = {{PW{1'b0}}, addr_i};
    else              src = ale_q;
    if (win_en) eff_addr = {page, src[OFS_W-1:0]};
    else        eff_addr = src;
  end
endmodule

// File: rtl/hpw_half_pack.sv
module hpw_half_pack #(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode16,
  input  logic          ale,
  input  logic          strobe_ok,
  input  logic          rnw,
  input  logic [DW-1:0] ad_i,
  output logic          issue,
  output logic          second_rd,
  output logic [DW-1:0] wdata
);
  logic          half_q, half_d;
  logic [HW-1:0] lo_q, lo_d;

  always_comb begin
    half_d = half_q;
    lo_d   = lo_q;
    if (ale) begin
      half_d = 1'b0;
    end else if (strobe_ok && mode16) begin
      half_d = ~half_q;
      if (!half_q && !rnw) lo_d = ad_i[HW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      half_q <= half_d;
      lo_q   <= lo_d;
    end
  end

  always_comb begin
    issue     = strobe_ok && (!mode16 || (rnw ? !half_q : half_q));
    second_rd = strobe_ok && mode16 && rnw && half_q;
    wdata     = mode16 ? {ad_i[HW-1:0], lo_q} : ad_i;
  end
endmodule

// File: rtl/hpw_bus_master.sv
module hpw_bus_master #(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode16,
  input  logic          issue,
  input  logic          second_rd,
  input  logic [DW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          m_req,
  output logic          m_we,
  output logic [DW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ack,
  output logic [DW-1:0] rdata_o
);
  logic          busy_q, busy_d;
  logic          we_q, we_d;
  logic [DW-1:0] addr_q, addr_d, wd_q, wd_d, rd_q, rd_d;
  logic [HW-1:0] hi_q, hi_d;
  logic          done;

  assign done = busy_q && m_ack;

  always_comb begin
    busy_d = busy_q;
    we_d   = we_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    hi_d   = hi_q;
    if (issue) begin
      busy_d = 1'b1;
      we_d   = we;
      addr_d = addr;
      wd_d   = wdata;
    end else if (done) begin
      busy_d = 1'b0;
      if (!we_q) begin
        hi_d = m_rdata[DW-1:HW];
        rd_d = mode16 ? {{(DW-HW){1'b0}}, m_rdata[HW-1:0]} : m_rdata;
      end
    end else if (second_rd) begin
      rd_d = {{(DW-HW){1'b0}}, hi_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      hi_q   <= '0;
    end else begin
      busy_q <= busy_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      hi_q   <= hi_d;
    end
  end

  assign m_req   = busy_q;
  assign m_we    = we_q;
  assign m_addr  = addr_q;
  assign m_wdata = wd_q;
  assign rdata_o = rd_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_wdata) && $stable(m_we))); // R9
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack) |=> !m_req); // R9
endmodule

// File: rtl/hpw_host_port.sv
module hpw_host_port
  import hpw_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 16,
  localparam int PW   = DW - OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             win_en,
  input  logic             cpu_page_we,
  input  logic [PW-1:0]    cpu_page_wdata,
  input  logic             h_ale,
  input  logic             h_strobe,
  input  logic             h_rnw,
  input  logic [DW-1:0]    h_ad_i,
  input  logic [OFS_W-1:0] h_addr_i,
  output logic [DW-1:0]    h_rdata,
  output logic             h_ready,
  output logic             m_req,
  output logic             m_we,
  output logic [DW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  input  logic [DW-1:0]    m_rdata,
  input  logic             m_ack
);
  hpw_mode_e     mode;
  logic          mode16, strobe_ok, issue, second_rd;
  logic [PW-1:0] page;
  logic [DW-1:0] eff_addr, pk_wdata;

  assign mode      = hpw_mode_e'(mode_sel);
  assign mode16    = (mode == HPW_MUX16);
  assign strobe_ok = h_strobe && !m_req;
  assign h_ready   = !m_req;

  hpw_page_reg #(.PW(PW)) u_page (
    .clk(clk), .rst_n(rst_n), .we(cpu_page_we), .wdata(cpu_page_wdata), .page_o(page)
  );

  hpw_addr_latch #(.DW(DW), .OFS_W(OFS_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ale(h_ale), .ad_i(h_ad_i),
    .addr_i(h_addr_i), .win_en(win_en), .page(page), .eff_addr(eff_addr)
  );

  hpw_half_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .ale(h_ale), .strobe_ok(strobe_ok),
    .rnw(h_rnw), .ad_i(h_ad_i), .issue(issue), .second_rd(second_rd), .wdata(pk_wdata)
  );

  hpw_bus_master #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .issue(issue), .second_rd(second_rd),
    .addr(eff_addr), .we(!h_rnw), .wdata(pk_wdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack), .rdata_o(h_rdata)
  );

  AST_WINDOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_req) && $past(win_en)) |-> (m_addr[DW-1:OFS_W] == $past(page))); // R7
  AST_BUSY_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (h_strobe && !h_ready) |=> ($stable(m_addr) && $stable(m_wdata) && $stable(m_we))); // R11
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack) |=> h_ready); // R9
  AST_WORD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_strobe && h_ready && !mode16) |=> m_req); // R9
endmodule

// File: tb/tb_hpw_host_port.sv
module tb_hpw_host_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        win_en, cpu_page_we;
  logic [15:0] cpu_page_wdata;
  logic        h_ale, h_strobe, h_rnw;
  logic [31:0] h_ad_i;
  logic [15:0] h_addr_i;
  logic [31:0] h_rdata;
  logic        h_ready, m_req, m_we, m_ack;
  logic [31:0] m_addr, m_wdata, m_rdata;

  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  int          lat = 0, cnt = 0, txn = 0;
  logic [31:0] last_addr, last_wdata;
  logic        last_we;

  always #10 clk = ~clk;

  hpw_host_port dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .win_en(win_en),
    .cpu_page_we(cpu_page_we), .cpu_page_wdata(cpu_page_wdata),
    .h_ale(h_ale), .h_strobe(h_strobe), .h_rnw(h_rnw), .h_ad_i(h_ad_i),
    .h_addr_i(h_addr_i), .h_rdata(h_rdata), .h_ready(h_ready),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack)
  );

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0FF0;
  endfunction

  // Internal bus responder with a programmable acknowledge delay
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack <= 1'b0; m_rdata <= '0; cnt <= 0;
    end else if (m_req && !m_ack) begin
      if (cnt == lat) begin
        m_ack <= 1'b1; m_rdata <= rd_fn(m_addr); cnt <= 0;
        txn <= txn + 1; last_addr <= m_addr; last_we <= m_we; last_wdata <= m_wdata;
      end else cnt <= cnt + 1;
    end else m_ack <= 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ale_pulse(input logic [31:0] v);
    @(negedge clk); h_ale = 1'b1; h_ad_i = v;
    @(negedge clk); h_ale = 1'b0;
  endtask

  task automatic strobe(input logic rnw, input logic [31:0] d, input logic [15:0] a,
                        output int busy_n);
    @(negedge clk); h_strobe = 1'b1; h_rnw = rnw; h_ad_i = d; h_addr_i = a;
    @(negedge clk); h_strobe = 1'b0;
    busy_n = 0;
    while (!h_ready) begin busy_n++; @(negedge clk); end
  endtask

  task automatic set_page(input logic [15:0] p);
    @(negedge clk); cpu_page_we = 1'b1; cpu_page_wdata = p;
    @(negedge clk); cpu_page_we = 1'b0;
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] m, input logic w,
                                           input logic [15:0] pg, input logic [31:0] a);
    logic [31:0] s;
    s = (m == 2'd1) ? a : {16'h0, a[15:0]};
    return w ? {pg, s[15:0]} : s;
  endfunction

  // One complete host access with expected values computed here
  task automatic access(input logic [1:0] m, input logic w, input logic [15:0] pg,
                        input logic [31:0] a, input logic rnw, input logic [31:0] d,
                        input string req);
    int b, t0;
    logic [31:0] ea, junk;
    ea = exp_addr(m, w, pg, a);
    junk = $urandom;
    mode_sel = m; win_en = w;
    if (m == 2'd0) begin
      ale_pulse({junk[31:16], a[15:0]});
      t0 = txn;
      if (!rnw) begin
        strobe(1'b0, {junk[15:0], d[15:0]}, 16'h0, b);
        chk({req, " R5 first half no access"}, txn - t0, 0);
        strobe(1'b0, {junk[31:16], d[31:16]}, 16'h0, b);
        chk({req, " R5 one write"}, txn - t0, 1);
        chk({req, " R5 write data"}, last_wdata, d);
      end else begin
        strobe(1'b1, junk, 16'h0, b);
        chk({req, " R6 one read"}, txn - t0, 1);
        chk({req, " R6 low half"}, h_rdata, {16'h0, rd_fn(ea) & 32'hFFFF});
        strobe(1'b1, junk, 16'h0, b);
        chk({req, " R6 no second access"}, txn - t0, 1);
        chk({req, " R6 high half"}, h_rdata, {16'h0, rd_fn(ea) >> 16});
      end
      chk({req, " R4 addr"}, last_addr, ea);
    end else begin
      if (m == 2'd1) ale_pulse(a);
      t0 = txn;
      strobe(rnw, d, a[15:0], b);
      chk({req, " R2/R3 one access"}, txn - t0, 1);
      chk({req, " R2/R3 addr"}, last_addr, ea);
      chk({req, " R2/R3 we"}, {31'h0, last_we}, {31'h0, !rnw});
      if (!rnw) chk({req, " R2/R3 wdata"}, last_wdata, d);
      else      chk({req, " R10 read data"}, h_rdata, rd_fn(ea));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b, t0;
    logic [15:0] pg;
    logic [31:0] rd_before;
    void'($urandom(32'd1234));
    rst_n = 1'b0; mode_sel = 2'd1; win_en = 1'b0; cpu_page_we = 1'b0; cpu_page_wdata = '0;
    h_ale = 1'b0; h_strobe = 1'b0; h_rnw = 1'b1; h_ad_i = '0; h_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'h0, h_ready}, 32'h1);
    chk("R1 req", {31'h0, m_req}, 32'h0);
    chk("R1 rdata", h_rdata, 32'h0);
    access(2'd2, 1'b1, 16'h0000, 32'h0000_1234, 1'b1, 32'h0, "R1 page zero");

    set_page(16'hBEEF);
    access(2'd1, 1'b1, 16'hBEEF, 32'h1234_5678, 1'b0, 32'hCAFE_F00D, "R7 mux32");
    access(2'd0, 1'b1, 16'hBEEF, 32'h0000_9ABC, 1'b0, 32'h1122_3344, "R7 mux16");
    access(2'd3, 1'b1, 16'hBEEF, 32'h0000_0042, 1'b1, 32'h0, "R7 sep");
    // R8: host writes of all ones and all zeros to the bus must not move the page
    access(2'd1, 1'b0, 16'hBEEF, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF, "R8 host write");
    access(2'd2, 1'b0, 16'hBEEF, 32'h0000_FFFF, 1'b0, 32'h0000_0000, "R8 host write");
    access(2'd2, 1'b1, 16'hBEEF, 32'h0000_0777, 1'b1, 32'h0, "R8 page kept");

    // R9 busy length for several acknowledge delays
    for (int l = 0; l < 4; l++) begin
      lat = l; mode_sel = 2'd2; win_en = 1'b0;
      strobe(1'b1, 32'h0, 16'h0100, b);
      chk("R9 busy cycles", b, l + 2);
    end

    // R10 write ack leaves read data untouched
    rd_before = h_rdata;
    lat = 1;
    strobe(1'b0, 32'h0BAD_0BAD, 16'h0200, b);
    chk("R10 write keeps rdata", h_rdata, rd_before);

    // R11 strobe while busy
    lat = 5; mode_sel = 2'd2; t0 = txn;
    @(negedge clk); h_strobe = 1'b1; h_rnw = 1'b0; h_ad_i = 32'hAAAA_0001; h_addr_i = 16'h0300;
    @(negedge clk); h_ad_i = 32'h5555_0002; h_addr_i = 16'h0400;
    @(negedge clk); h_strobe = 1'b0;
    while (!h_ready) @(negedge clk);
    chk("R11 one access", txn - t0, 1);
    chk("R11 first data kept", last_wdata, 32'hAAAA_0001);
    chk("R11 first addr kept", last_addr, 32'h0000_0300);

    // Random mix
    pg = 16'hBEEF;
    for (int i = 0; i < 200; i++) begin
      logic [1:0] m;
      logic w, r;
      m = 2'($urandom_range(0, 3));
      w = 1'($urandom);
      r = 1'($urandom);
      lat = $urandom_range(0, 3);
      if ($urandom_range(0, 9) == 0) begin
        pg = 16'($urandom);
        set_page(pg);
      end
      access(m, w, pg, $urandom, r, $urandom, "random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule